// File: doc/BRIEF.md
# Windowed link throughput analyzer

This block sits beside one link port and measures a single statistic over a time window. The statistic is one of three kinds: received payload beats, transmitted payload beats, or the clock cycles during which a chosen low-power link state is active. Each payload beat stands for 16 bytes of data. Software turns bandwidth into bytes per second by multiplying the count by 16 and dividing by the window length.

Software drives the block through a simple 32-bit register bus with separate read and write strobes. It selects the statistic and the window code in one control word, and then reads back a 64-bit result as two 32-bit words. Reading the upper word also captures the lower word, so the two halves always belong to the same sample. A window is either manual, lasting as long as the enable bit stays set, or timed, lasting a fixed number of microseconds. The number of clock cycles per microsecond is set by a parameter.

Top module: `tput_window_meter`

## Requirements
- R1: After reset, the control word, the upper result word and the lower result word all read as zero.
- R2: The control word is at address 0x10. Bits 31:24 hold the statistic select, bits 15:8 hold the window code and bit 0 is the enable. All other bits read as zero.
- R3: The select codes are as follows. Code 0x00 counts cycles with `rx_beat` high. Code 0x01 counts cycles with `tx_beat` high. Code 0x10+k counts cycles with `lp_state[k]` high. Any other code counts nothing. The result grows by at most one per cycle.
- R4: Writing the control word with bit 0 set clears the result and starts a new measurement. Events are counted from the cycle after that write.
- R5: Window code 0x00, and any code not listed in R6, selects manual mode. In manual mode the result accumulates for as long as the enable bit stays set. Writing the control word with bit 0 clear stops counting, and the result then holds.
- R6: The timed codes are 0x01 = 1 ms, 0x02 = 10 ms, 0x03 = 100 ms, 0x04 = 1 s, 0x05 = 2 s, 0x06 = 4 s and 0xFF = 4 us. A timed window counts for exactly that many microseconds times `CYC_PER_US` cycles after the write. After that the enable bit reads 0 and the result is frozen.
- R7: A control write with bit 0 set while a window is running restarts the measurement from zero, with a fresh window.
- R8: A read of address 0x18 returns result bits 63:32 and captures result bits 31:0 into a shadow register. A read of address 0x14 returns that shadow value, which is zero until the first read of 0x18.
- R9: Reads of any other address return zero. Writes to any other address leave the control word and the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_rd` |
| rx_beat | input | 1 | One received 16-byte payload unit this cycle |
| tx_beat | input | 1 | One transmitted 16-byte payload unit this cycle |
| lp_state | input | NUM_LP | One bit for each low-power link state, high while that state is active |

## Verification
The hardest case to reach is a torn result, where the live count changes between the upper-word read and the lower-word read. The stimulus keeps payload beats flowing in the gap between the two reads, and then checks that the lower word still matches the count at the moment the upper word was read. Timed windows are made reachable by setting the cycles-per-microsecond parameter to 1, so the event pattern is driven past the 4 us, 1 ms and 10 ms window ends. The expected count stops at each window boundary, and the enable bit reads 0 once the window has closed.

// File: rtl/tpm_pkg.sv
// Shared constants for the windowed throughput meter: register addresses,
// control field positions, statistic select codes, and the window code table.
// Assumes the control word is 32 bits wide.
package tpm_pkg;
    localparam int unsigned REG_W   = 32;
    localparam logic [7:0]  ADDR_CTRL = 8'h10;
    localparam logic [7:0]  ADDR_LO   = 8'h14;
    localparam logic [7:0]  ADDR_HI   = 8'h18;
    localparam int unsigned SEL_LSB = 24;
    localparam int unsigned DUR_LSB = 8;
    localparam int unsigned EN_BIT  = 0;
    localparam logic [7:0]  SEL_RX      = 8'h00;
    localparam logic [7:0]  SEL_TX      = 8'h01;
    localparam logic [7:0]  SEL_LP_BASE = 8'h10;

    // Window length in microseconds; zero means manual (open-ended) mode.
    function automatic logic [31:0] dur_code_to_us(input logic [7:0] code);
        case (code)
            8'h01:   return 32'd1000;
            8'h02:   return 32'd10000;
            8'h03:   return 32'd100000;
            8'h04:   return 32'd1000000;
            8'h05:   return 32'd2000000;
            8'h06:   return 32'd4000000;
            8'hFF:   return 32'd4;
            default: return 32'd0;
        endcase
    endfunction
endpackage

// File: rtl/tpm_event_select.sv
// Picks the one-bit event that feeds the accumulator, from the statistic
// select code. Codes that are not defined give a constant zero.
// Assumes NUM_LP is 16 or less, so every state code fits in 0x10..0x1F.
module tpm_event_select
    import tpm_pkg::*;
#(
    parameter int NUM_LP = 4
) (
    input  logic [7:0]        sel,
    input  logic              rx_beat,
    input  logic              tx_beat,
    input  logic [NUM_LP-1:0] lp_state,
    output logic              hit
);
    // Decode the select code into the matching event strobe.
    always_comb begin
        hit = 1'b0;
        if (sel == SEL_RX) hit = rx_beat;
        if (sel == SEL_TX) hit = tx_beat;
        for (int k = 0; k < NUM_LP; k++) begin
            if (sel == SEL_LP_BASE + 8'(k)) hit = lp_state[k];
        end
    end
endmodule

// File: rtl/tpm_window_timer.sv
// Holds the measurement-running flag and, in timed mode, counts the cycles
// left in the window. A start loads the window length from the code table.
// Assumes CYC_PER_US * 4000000 fits in WIN_W bits.
module tpm_window_timer
    import tpm_pkg::*;
#(
    parameter int CYC_PER_US = 500,
    parameter int WIN_W      = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic [7:0] dur_code,
    output logic       running,
    output logic       timed
);
    logic [31:0]      win_us;
    logic [WIN_W-1:0] win_len;
    logic [WIN_W-1:0] remaining;

    // Turn the window code into a cycle count.
    always_comb begin
        win_us  = dur_code_to_us(dur_code);
        win_len = WIN_W'(win_us) * WIN_W'(CYC_PER_US);
    end

    // Start, stop and count down the window; close it on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            timed     <= 1'b0;
            remaining <= '0;
        end else if (start) begin
            running   <= 1'b1;
            timed     <= (win_us != 32'd0);
            remaining <= win_len;
        end else if (stop) begin
            running   <= 1'b0;
        end else if (running && timed) begin
            if (remaining == WIN_W'(1)) running <= 1'b0;
            remaining <= remaining - WIN_W'(1);
        end
    end
endmodule

// File: rtl/tpm_accum.sv
// Wide event accumulator: a clear has priority, then the count goes up by
// one on each increment. Assumes CNT_W is wide enough never to wrap.
module tpm_accum #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    // Clear on a new measurement, otherwise count qualified events.
    always_ff @(posedge clk) begin
        if (!rst_n)     value <= '0;
        else if (clear) value <= '0;
        else if (inc)   value <= value + CNT_W'(1);
    end
endmodule

// File: rtl/tput_window_meter.sv
// Top of the windowed throughput meter. It decodes the register bus, holds
// the control fields and the low-word shadow, and connects the event
// selector, the window timer and the accumulator.
// Assumes single-cycle bus strobes with read data returned in the same cycle.
module tput_window_meter
    import tpm_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_LP     = 4,
    parameter int CYC_PER_US = 500,
    parameter int WIN_W      = 40,
    parameter int CNT_W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rx_beat,
    input  logic              tx_beat,
    input  logic [NUM_LP-1:0] lp_state
);
    localparam int HALF = CNT_W / 2;

    logic [7:0]       ctrl_sel;
    logic [7:0]       ctrl_dur;
    logic [HALF-1:0]  shadow_lo;
    logic [CNT_W-1:0] acc_value;
    logic             ctrl_wr, meas_start, meas_stop;
    logic             meas_running, meas_timed, ev_hit;
    logic [7:0]       wr_sel, wr_dur;

    // Decode control writes and the fields they carry.
    always_comb begin
        ctrl_wr    = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
        meas_start = ctrl_wr && reg_wdata[EN_BIT];
        meas_stop  = ctrl_wr && !reg_wdata[EN_BIT];
        wr_sel     = reg_wdata[SEL_LSB +: 8];
        wr_dur     = reg_wdata[DUR_LSB +: 8];
    end

    // Hold the statistic select and window code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_sel <= '0;
            ctrl_dur <= '0;
        end else if (ctrl_wr) begin
            ctrl_sel <= wr_sel;
            ctrl_dur <= wr_dur;
        end
    end

    // Capture the low half when the high half is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow_lo <= '0;
        else if (reg_rd && reg_addr == ADDR_W'(ADDR_HI))
            shadow_lo <= acc_value[HALF-1:0];
    end

    tpm_event_select #(.NUM_LP(NUM_LP)) i_sel (
        .sel      (ctrl_sel),
        .rx_beat  (rx_beat),
        .tx_beat  (tx_beat),
        .lp_state (lp_state),
        .hit      (ev_hit)
    );

    tpm_window_timer #(.CYC_PER_US(CYC_PER_US), .WIN_W(WIN_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (meas_start),
        .stop     (meas_stop),
        .dur_code (wr_dur),
        .running  (meas_running),
        .timed    (meas_timed)
    );

    tpm_accum #(.CNT_W(CNT_W)) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (meas_start),
        .inc   (meas_running && ev_hit),
        .value (acc_value)
    );

    // Return the addressed register; unknown addresses read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == ADDR_W'(ADDR_CTRL))
                reg_rdata = {ctrl_sel, 8'h00, ctrl_dur, 7'h00, meas_running};
            else if (reg_addr == ADDR_W'(ADDR_HI))
                reg_rdata = acc_value[CNT_W-1:HALF];
            else if (reg_addr == ADDR_W'(ADDR_LO))
                reg_rdata = shadow_lo;
        end
    end
endmodule

// File: rtl/tpm_checker.sv
// Temporal checks on the throughput meter, attached to the top by bind.
// Assumes the default 64-bit result with 32-bit halves.
module tpm_checker
    import tpm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [CNT_W-1:0]  result,
    input logic [31:0]       shadow,
    input logic              running,
    input logic              timed
);
    logic cw, cw_en;
    assign cw    = reg_wr && reg_addr == ADDR_W'(ADDR_CTRL);
    assign cw_en = cw && reg_wdata[EN_BIT];

    assert_clear_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cw_en |=> result == '0);

    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_en |=> (result >= $past(result)) && ((result - $past(result)) <= CNT_W'(1)));

    assert_manual_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !timed && !cw) |=> running);

    assert_frozen_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cw) |=> $stable(result));

    assert_shadow_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(ADDR_HI)) |=> shadow == $past(result[31:0]));
endmodule

bind tput_window_meter tpm_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tpm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .result    (acc_value),
    .shadow    (shadow_lo),
    .running   (meas_running),
    .timed     (meas_timed)
);

// File: tb/test_tput_window_meter.sv
module test_tput_window_meter;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_LP     = 4;
    localparam int NVEC       = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              rx_beat = 1'b0, tx_beat = 1'b0;
    logic [NUM_LP-1:0] lp_state = '0;

    int nchk = 0;
    int nfail = 0;

    // {select, window code, cycles driven}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 32'd20},
        {8'h01, 8'h00, 32'd30},
        {8'h10, 8'hFF, 32'd20},
        {8'h12, 8'h00, 32'd17},
        {8'h01, 8'h01, 32'd1200},
        {8'h05, 8'h00, 32'd10},
        {8'h00, 8'h37, 32'd25},
        {8'h13, 8'h02, 32'd10005},
        {8'h11, 8'hFF, 32'd3}
    };

    tput_window_meter #(.ADDR_W(8), .NUM_LP(NUM_LP), .CYC_PER_US(1)) i_tput_window_meter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_beat(rx_beat), .tx_beat(tx_beat), .lp_state(lp_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int win_cycles(input logic [7:0] code);
        case (code)
            8'h01: return 1000;
            8'h02: return 10000;
            8'h03: return 100000;
            8'h04: return 1000000;
            8'h05: return 2000000;
            8'h06: return 4000000;
            8'hFF: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit pattern_hit(input logic [7:0] sel, input int i);
        if (sel == 8'h00) return (i % 2) == 0;
        if (sel == 8'h01) return (i % 3) == 0;
        for (int k = 0; k < NUM_LP; k++)
            if (sel == 8'h10 + 8'(k)) return (i % (k + 2)) == 0;
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    // Drive the mixed event pattern for n cycles, then go idle.
    task automatic drive_pattern(input int n);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            rx_beat = (i % 2) == 0;
            tx_beat = (i % 3) == 0;
            for (int k = 0; k < NUM_LP; k++) lp_state[k] = (i % (k + 2)) == 0;
        end
        @(negedge clk);
        rx_beat = 1'b0; tx_beat = 1'b0; lp_state = '0;
    endtask

    task automatic drive_rx(input int n);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            rx_beat = 1'b1;
        end
        @(negedge clk);
        rx_beat = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rd_reg(8'h10, d); check("R1 ctrl", d, 32'h0);
        rd_reg(8'h18, d); check("R1 hi", d, 32'h0);
        rd_reg(8'h14, d); check("R1 lo", d, 32'h0);

        // Table walk: R3, R5, R6 across select and window codes
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] sel, dur;
            int n, w, lim, exp_cnt;
            sel = VEC[v][47:40];
            dur = VEC[v][39:32];
            n   = int'(VEC[v][31:0]);
            w   = win_cycles(dur);
            lim = (w != 0 && w < n) ? w : n;
            exp_cnt = 0;
            for (int i = 1; i <= lim; i++) if (pattern_hit(sel, i)) exp_cnt++;
            wr_reg(8'h10, {sel, 8'h00, dur, 8'h01});
            drive_pattern(n);
            rd_reg(8'h18, d); check("R3 hi", d, 32'h0);
            rd_reg(8'h14, d); check(w != 0 ? "R6 count" : "R3 count", d, 32'(exp_cnt));
            rd_reg(8'h10, d); check(w != 0 ? "R6 enable" : "R5 enable", {31'h0, d[0]}, (w != 0) ? 32'h0 : 32'h1);
        end

        // R8: shadow keeps the value from the high read while beats continue
        wr_reg(8'h10, 32'h0000_0001);
        drive_rx(7);
        rd_reg(8'h18, d); check("R8 hi", d, 32'h0);
        drive_rx(5);
        rd_reg(8'h14, d); check("R8 lo coherent", d, 32'd7);
        rd_reg(8'h18, d);
        rd_reg(8'h14, d); check("R8 lo refresh", d, 32'd12);

        // R5: clearing enable freezes the result
        wr_reg(8'h10, 32'h0000_0000);
        drive_rx(6);
        rd_reg(8'h18, d);
        rd_reg(8'h14, d); check("R5 frozen", d, 32'd12);
        rd_reg(8'h10, d); check("R5 ctrl", d, 32'h0);

        // R7: restart of a running timed window
        wr_reg(8'h10, 32'h0000_FF01);
        drive_rx(2);
        wr_reg(8'h10, 32'h0000_FF01);
        drive_rx(10);
        rd_reg(8'h18, d);
        rd_reg(8'h14, d); check("R7 restart", d, 32'd4);

        // R9: other addresses
        wr_reg(8'h20, 32'hFFFF_FFFF);
        rd_reg(8'h20, d); check("R9 unmapped read", d, 32'h0);
        rd_reg(8'h10, d); check("R9 ctrl untouched", d, 32'h0000_FF00);
        rd_reg(8'h18, d);
        rd_reg(8'h14, d); check("R9 result untouched", d, 32'd4);

        // R2: field placement and reserved bits
        wr_reg(8'h10, 32'h1234_ABFE);
        rd_reg(8'h10, d); check("R2 readback", d, 32'h1200_AB00);

        // R4: a new start clears the previous result
        wr_reg(8'h10, 32'h1000_0001);
        rd_reg(8'h18, d);
        rd_reg(8'h14, d); check("R4 cleared", d, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule